// File: doc/BRIEF.md
# Audio Serial Port Bit and Frame Clock Generator

This block produces the timing for a stereo audio serial port. All of its logic runs from one module clock. In controller mode it divides the module clock down to a bit clock. It counts bit clocks into frames whose length is a power of two, and from that count it derives a frame (left/right) clock. It also drives a one-cycle frame-start strobe and a slot counter, so that neighbouring shift logic knows which bit of the frame is on the wire. In follower mode the generator stops. The bit and frame clocks then come from the pins and are passed through with the configured polarity.

All settings are held in one 32-bit control word, written through a plain address / write-enable / data port. In controller mode a new divider or format setting does not cut into the frame in progress. The settings written are held aside and switched in when the current frame ends. Bits 5:4 (word size, where code 1 means 16-bit samples) are accepted but do not change the clocking.

Top module: `aud_clkgen`

## Requirements
- R1: A write takes effect only when `cfg_addr` equals the parameter `CTRL_ADDR` (default 0). A write to any other address changes no setting and no output.
- R2: Bits 12:9 select the bit-clock ratio in module clocks. Codes 0..13 give 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192, and codes 14 and 15 also give 192. Any even ratio gives a bit clock that is high for ratio/2 module clocks and low for ratio/2.
- R3: With ratio code 0 in controller mode, `bclk_out` is the module clock itself, with the polarity of R7 applied.
- R4: Bits 8:6 hold a code N that sets a frame of 2^(N+4) bit clocks. Codes 5, 6 and 7 give 256. `slot_cnt` runs from 0 to length-1 and advances at each falling edge of the generated bit clock.
- R5: Bits 3:2 select the format. Codes 0 (I2S), 1 (left-justified) and 2 (right-justified) give a frame clock that is low for slots 0..length/2-1 and high for the rest, at normal polarity. Code 3 (PCM) gives a frame clock that is high during slot 0 only.
- R6: `frame_start` is a single module-clock pulse. It is high in the first cycle of slot 1 in I2S format and in the first cycle of slot 0 in the other formats.
- R7: When bit 14 is 1, the bit clock is inverted. Bit 13 works the other way round: 1 gives normal frame-clock polarity and 0 inverts it.
- R8: When bit 15 is 1 (follower mode), `bclk_out` is `bclk_in` and `lrck_out` is `lrck_in`, each with the R7 polarity. `slot_cnt` stays 0 and no `frame_start` pulse occurs.
- R9: In controller mode, new divider, frame-length, format and polarity settings take effect at the next frame boundary. The frame in progress keeps its length.
- R10: After reset the settings equal the control word 0x2210: controller mode, ratio 2, a 16-slot frame, I2S, normal polarity. `bclk_out`, `lrck_out`, `frame_start` and `slot_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | 32 | Control word |
| bclk_in | input | 1 | Bit clock from the pin (follower mode) |
| lrck_in | input | 1 | Frame clock from the pin (follower mode) |
| bclk_out | output | 1 | Bit clock after mode selection and polarity |
| lrck_out | output | 1 | Frame clock after mode selection and polarity |
| frame_start | output | 1 | One-cycle frame-start strobe |
| slot_cnt | output | 8 | Bit position within the frame |

## Verification
On every cycle the checker confirms four things. The slot count never passes the end of the active frame, and it only steps by one or wraps to zero. The frame-start strobe is one cycle wide and falls on slot 0 or 1. Follower mode keeps the counter and strobe idle, and writes to a foreign address leave the held settings untouched. Other behaviour can only be shown by the bench's scenarios, because each depends on a count across a whole frame: the divider ratios and duty cycle, the frame length and the reserved-code clamp, the frame-clock shape of each format, the reversed polarity bit, the clock pass-through, and the deferral of a mid-frame write to the next boundary.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  localparam int CTRL_W        = 32;
  localparam int RATIO_W       = 8;
  localparam int FRAME_LOG_MIN = 4;
  localparam int FRAME_LOG_MAX = 8;

  // control word bit positions (decoded by software-facing neighbours)
  localparam int B_MODE  = 15;
  localparam int B_BINV  = 14;
  localparam int B_LNORM = 13;
  localparam int B_BDIV  = 9;
  localparam int B_FDIV  = 6;
  localparam int B_FMT   = 2;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_PCM   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       bclk_inv;
    logic       lrck_norm;
    logic [3:0] bdiv;
    logic [2:0] fdiv;
    fmt_e       fmt;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{bclk_inv: 1'b0, lrck_norm: 1'b1,
                                     bdiv: 4'd1, fdiv: 3'd0, fmt: FMT_I2S};

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code);
    case (code)
      4'd0:    return RATIO_W'(1);
      4'd1:    return RATIO_W'(2);
      4'd2:    return RATIO_W'(4);
      4'd3:    return RATIO_W'(6);
      4'd4:    return RATIO_W'(8);
      4'd5:    return RATIO_W'(12);
      4'd6:    return RATIO_W'(16);
      4'd7:    return RATIO_W'(24);
      4'd8:    return RATIO_W'(32);
      4'd9:    return RATIO_W'(48);
      4'd10:   return RATIO_W'(64);
      4'd11:   return RATIO_W'(96);
      4'd12:   return RATIO_W'(128);
      default: return RATIO_W'(192);
    endcase
  endfunction

  function automatic logic [3:0] frame_log(input logic [2:0] code);
    if (code > 3'd4) return 4'(FRAME_LOG_MAX);
    return 4'(code) + 4'(FRAME_LOG_MIN);
  endfunction

endpackage

// File: rtl/aud_cfg_reg.sv
module aud_cfg_reg
  import aud_clk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output clk_cfg_t          cfg,
  output logic              follower
);

  logic hit;
  logic unused_wdata;

  assign hit          = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign unused_wdata = ^{wdata[CTRL_W-1:16], wdata[5:4], wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CFG_RESET;
      follower <= 1'b0;
    end else if (hit) begin
      cfg.bclk_inv  <= wdata[B_BINV];
      cfg.lrck_norm <= wdata[B_LNORM];
      cfg.bdiv      <= wdata[B_BDIV +: 4];
      cfg.fdiv      <= wdata[B_FDIV +: 3];
      cfg.fmt       <= fmt_e'(wdata[B_FMT +: 2]);
      follower      <= wdata[B_MODE];
    end
  end

endmodule

// File: rtl/aud_bclk_div.sv
module aud_bclk_div
  import aud_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] bdiv,
  output logic       bclk,
  output logic       tick
);

  localparam int CNT_W = RATIO_W - 1;

  logic [RATIO_W-1:0] ratio;
  logic [CNT_W-1:0]   half;
  logic [CNT_W-1:0]   cnt;
  logic               bclk_q;
  logic               pass;
  logic               at_half;

  assign ratio   = ratio_of(bdiv);
  assign half    = ratio[RATIO_W-1:1];
  assign pass    = (ratio == RATIO_W'(1));
  assign at_half = (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bclk_q <= 1'b0;
    end else if (!run || pass) begin
      cnt    <= '0;
      bclk_q <= 1'b0;
    end else if (at_half) begin
      cnt    <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // a bit period ends on the falling edge of the generated clock
  assign tick = run && (pass || (at_half && bclk_q));
  assign bclk = pass ? clk : bclk_q;

endmodule

// File: rtl/aud_frame_gen.sv
module aud_frame_gen
  import aud_clk_pkg::*;
#(
  parameter int SLOT_W = FRAME_LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  clk_cfg_t          next_cfg,
  output clk_cfg_t          cur_cfg,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] last_slot,
  output logic              lrck_raw,
  output logic              frame_start
);

  logic [3:0]        flog;
  logic [SLOT_W:0]   len_ext;
  logic              wrap;
  logic [SLOT_W-1:0] nxt;
  logic              start_i2s;
  logic [SLOT_W-1:0] start_pos;

  assign flog      = frame_log(cur_cfg.fdiv);
  assign len_ext   = (SLOT_W+1)'(1) << flog;
  assign last_slot = SLOT_W'(len_ext - 1'b1);
  assign wrap      = tick && (slot == last_slot);
  assign nxt       = wrap ? '0 : slot + 1'b1;
  // the frame about to begin uses the settings switched in at the wrap
  assign start_i2s = wrap ? (next_cfg.fmt == FMT_I2S) : (cur_cfg.fmt == FMT_I2S);
  assign start_pos = SLOT_W'(start_i2s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot        <= '0;
      frame_start <= 1'b0;
      cur_cfg     <= CFG_RESET;
    end else if (!run) begin
      slot        <= '0;
      frame_start <= 1'b0;
      cur_cfg     <= next_cfg;
    end else begin
      frame_start <= tick && (nxt == start_pos);
      if (tick) slot <= nxt;
      if (wrap) cur_cfg <= next_cfg;
    end
  end

  assign lrck_raw = (cur_cfg.fmt == FMT_PCM) ? (slot == '0) : (slot > (last_slot >> 1));

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr_en,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     bclk_in,
  input  logic                     lrck_in,
  output logic                     bclk_out,
  output logic                     lrck_out,
  output logic                     frame_start,
  output logic [FRAME_LOG_MAX-1:0] slot_cnt
);

  localparam int SLOT_W = FRAME_LOG_MAX;

  clk_cfg_t          shadow_cfg;
  clk_cfg_t          cur_cfg;
  logic              follower;
  logic              bclk_gen;
  logic              tick;
  logic              lrck_raw;
  logic [SLOT_W-1:0] last_slot;

  aud_cfg_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg      (shadow_cfg),
    .follower (follower)
  );

  aud_bclk_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!follower),
    .bdiv  (cur_cfg.bdiv),
    .bclk  (bclk_gen),
    .tick  (tick)
  );

  aud_frame_gen #(.SLOT_W(SLOT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (!follower),
    .tick        (tick),
    .next_cfg    (shadow_cfg),
    .cur_cfg     (cur_cfg),
    .slot        (slot_cnt),
    .last_slot   (last_slot),
    .lrck_raw    (lrck_raw),
    .frame_start (frame_start)
  );

  assign bclk_out = (follower ? bclk_in : bclk_gen) ^ cur_cfg.bclk_inv;
  assign lrck_out = (follower ? lrck_in : lrck_raw) ^ ~cur_cfg.lrck_norm;

endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk
  import aud_clk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_wr_en,
  input logic [ADDR_W-1:0]        cfg_addr,
  input clk_cfg_t                 shadow_cfg,
  input logic                     follower,
  input logic                     frame_start,
  input logic [FRAME_LOG_MAX-1:0] slot_cnt,
  input logic [FRAME_LOG_MAX-1:0] last_slot
);

  // R1: foreign-address writes leave the held settings alone
  p_foreign_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr != ADDR_W'(CTRL_ADDR)) |=> $stable(shadow_cfg));

  // R4: slot count stays inside the active frame
  p_slot_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= last_slot);

  // R4: slot count steps by one or wraps to zero
  p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_cnt) |-> (slot_cnt == '0 ||
                            slot_cnt == FRAME_LOG_MAX'($past(slot_cnt) + 1'b1)));

  // R6: strobe is one module clock wide
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R6: strobe marks slot 0 or slot 1 only
  p_strobe_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> slot_cnt <= FRAME_LOG_MAX'(1));

  // R8: follower mode keeps the generator idle
  p_follower_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    follower |=> (slot_cnt == '0 && !frame_start));

endmodule

bind aud_clkgen aud_clkgen_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_addr    (cfg_addr),
  .shadow_cfg  (shadow_cfg),
  .follower    (follower),
  .frame_start (frame_start),
  .slot_cnt    (slot_cnt),
  .last_slot   (last_slot)
);

// File: tb/sim_aud_clkgen.sv
`timescale 1ns/100ps
module sim_aud_clkgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bclk_in = 1'b0;
  logic        lrck_in = 1'b0;
  logic        bclk_out, lrck_out, frame_start;
  logic [7:0]  slot_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  aud_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .frame_start(frame_start),
    .slot_cnt(slot_cnt)
  );

  // {bdiv, fdiv, fmt, binv, lnorm, ratio, length}
  localparam logic [27:0] VEC [0:8] = '{
    {4'd1,  3'd0, 2'd0, 1'b0, 1'b1, 8'd2,   9'd16},
    {4'd2,  3'd1, 2'd1, 1'b1, 1'b1, 8'd4,   9'd32},
    {4'd3,  3'd0, 2'd2, 1'b0, 1'b0, 8'd6,   9'd16},
    {4'd5,  3'd2, 2'd3, 1'b0, 1'b1, 8'd12,  9'd64},
    {4'd13, 3'd0, 2'd0, 1'b0, 1'b1, 8'd192, 9'd16},
    {4'd7,  3'd4, 2'd1, 1'b0, 1'b1, 8'd24,  9'd256},
    {4'd4,  3'd6, 2'd3, 1'b0, 1'b0, 8'd8,   9'd256},
    {4'd15, 3'd0, 2'd1, 1'b0, 1'b1, 8'd192, 9'd16},
    {4'd9,  3'd3, 2'd0, 1'b1, 1'b1, 8'd48,  9'd128}
  };

  function automatic logic [31:0] mk(input logic [3:0] bc, input logic [2:0] lc,
                                     input logic [1:0] fm, input logic binv,
                                     input logic lnorm, input logic foll);
    return {16'h0, foll, binv, lnorm, bc, lc, 2'b01, fm, 2'b00};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic measure(output int per, output int hb, output int hl,
                         output int b0, output int l0, output int s0);
    wait_fs();
    b0 = int'(bclk_out); l0 = int'(lrck_out); s0 = int'(slot_cnt);
    per = 0; hb = 0; hl = 0;
    do begin
      hb += int'(bclk_out); hl += int'(lrck_out); per++;
      @(negedge clk);
    end while (!frame_start);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=190000 cycles expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per, hb, hl, b0, l0, s0, n;
    // R10: reset state
    repeat (4) @(negedge clk);
    chk("R10 bclk_out in reset", int'(bclk_out), 0);
    chk("R10 lrck_out in reset", int'(lrck_out), 0);
    chk("R10 slot_cnt in reset", int'(slot_cnt), 0);
    chk("R10 frame_start in reset", int'(frame_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 slot after release", int'(slot_cnt), 0);

    // R1: write to a foreign address; reset settings must hold (R10)
    wr(8'h04, mk(4'd2, 3'd1, 2'd1, 1'b1, 1'b0, 1'b0));
    wait_fs();
    measure(per, hb, hl, b0, l0, s0);
    chk("R1/R10 period after foreign write", per, 32);
    chk("R1/R10 strobe slot after foreign write", s0, 1);
    chk("R1/R10 lrck at strobe after foreign write", l0, 0);

    // vector table
    for (int i = 0; i < 9; i++) begin
      logic [27:0] v;
      int r, len, fm, bi, ln, exp_l0, exp_hl;
      v   = VEC[i];
      r   = int'(v[16:9]);
      len = int'(v[8:0]);
      fm  = int'(v[20:19]);
      bi  = int'(v[18]);
      ln  = int'(v[17]);
      wr(8'h00, mk(v[27:24], v[23:21], v[20:19], v[18], v[17], 1'b0));
      wait_fs();
      measure(per, hb, hl, b0, l0, s0);
      exp_l0 = ((fm == 3) ? 1 : 0) ^ (1 - ln);
      exp_hl = (fm == 3) ? ((ln == 1) ? r : r * len - r) : r * len / 2;
      chk($sformatf("R2/R4 frame period vec%0d", i), per, r * len);
      chk($sformatf("R2 bclk high time vec%0d", i), hb, r * len / 2);
      chk($sformatf("R7 bclk level at strobe vec%0d", i), b0, bi);
      chk($sformatf("R6 strobe slot vec%0d", i), s0, (fm == 0) ? 1 : 0);
      chk($sformatf("R5/R7 lrck at strobe vec%0d", i), l0, exp_l0);
      chk($sformatf("R5 lrck high time vec%0d", i), hl, exp_hl);
    end

    // R3: ratio 1 passes the module clock
    wr(8'h00, mk(4'd0, 3'd0, 2'd1, 1'b0, 1'b1, 1'b0));
    wait_fs();
    measure(per, hb, hl, b0, l0, s0);
    chk("R3 period at ratio 1", per, 16);
    @(posedge clk); #1;
    chk("R3 bclk high with clk", int'(bclk_out), 1);
    @(negedge clk); #1;
    chk("R3 bclk low with clk", int'(bclk_out), 0);

    // R9: mid-frame write waits for the boundary
    wr(8'h00, mk(4'd1, 3'd0, 2'd1, 1'b0, 1'b1, 1'b0));
    wait_fs();
    wait_fs();
    wait_fs();
    n = 0;
    do begin
      if (n == 5) begin
        cfg_addr = 8'h00; cfg_wdata = mk(4'd2, 3'd0, 2'd1, 1'b0, 1'b1, 1'b0);
        cfg_wr_en = 1'b1;
      end else cfg_wr_en = 1'b0;
      n++;
      @(negedge clk);
    end while (!frame_start);
    cfg_wr_en = 1'b0;
    chk("R9 frame in progress keeps length", n, 32);
    n = 0;
    do begin n++; @(negedge clk); end while (!frame_start);
    chk("R9 next frame uses new ratio", n, 64);

    // R8: follower mode, bclk inverted, lrck inverted (bit 13 clear)
    wr(8'h00, mk(4'd1, 3'd0, 2'd0, 1'b1, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    bclk_in = 1'b1; lrck_in = 1'b0;
    @(negedge clk);
    chk("R8 bclk_out from pin inverted", int'(bclk_out), 0);
    chk("R8 lrck_out from pin inverted", int'(lrck_out), 1);
    bclk_in = 1'b0; lrck_in = 1'b1;
    @(negedge clk);
    chk("R8 bclk_out follows pin", int'(bclk_out), 1);
    chk("R8 lrck_out follows pin", int'(lrck_out), 0);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (frame_start || slot_cnt != 0) n++;
    end
    chk("R8 generator idle in follower mode", n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule